// File: doc/BRIEF.md
# Supply-Qualified Reset Release Timer

This block turns two comparator flags into a reset signal for the logic it guards. One flag reports that the supply has fallen below the detect level. The other reports that the supply has risen above a higher release level. Together they give a hysteresis band, nominally 5% of the detect level and between 3% and 7% of it. The active-low reset output drops on the first clock edge at which the low flag is seen. It rises again only after a programmable delay has built up while the supply stayed above the release level. The nominal delay is 370 ms, which is 370 ticks of a 1 ms timebase under the default parameters.

The delay store models a timing capacitor rather than a timer that clears. It gains one count per timebase tick while the supply is good and loses a fixed step per tick while the supply is low. It never drops below zero. A short dip therefore takes away only part of the stored delay, and the next release comes sooner than the full delay. While the supply sits between the two levels, both the store and the output keep their values. The analog comparators are outside this block. The `tick_i` input provides the timebase.

Top module: `por_release_timer`

## Requirements
- R1: While `rst_ni` is low, the output `rst_no` is 0 and the delay store is cleared to zero. A supply that is good from the end of reset, with a tick on every cycle, therefore releases `rst_no` after TPLH+1 clock edges.
- R2: A clock edge at which `below_det_i` is 1 drives `rst_no` to 0, with or without a tick.
- R3: A tick with `above_rel_i`=1 and `below_det_i`=0 raises the delay store by one. The store saturates at TPLH: extra charging time never pushes it past that value.
- R4: `rst_no` rises on the clock edge after the store reaches TPLH while the supply is good. From a store value c with a tick on every cycle, the release therefore comes after TPLH−c+1 edges.
- R5: A tick with `below_det_i`=1 lowers the store by DRAIN_STEP, saturating at zero. After n drain ticks from a full store, the release comes after TPLH−max(0, TPLH−n·DRAIN_STEP)+1 edges.
- R6: With both flags at 0 (supply inside the hysteresis band), the store and `rst_no` both keep their values.
- R7: When both flags are 1, the block acts exactly as for a low supply: it drains and holds reset low.
- R8: The store changes only on cycles with `tick_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| tick_i | input | 1 | Delay timebase strobe, one clock wide |
| below_det_i | input | 1 | Supply is below the detect level |
| above_rel_i | input | 1 | Supply is above the release level |
| rst_no | output | 1 | Reset to the guarded logic, active low |

## Verification
The bench sweeps the length of a supply dip from zero ticks until the store is fully drained. After each dip it measures the edge count to release against the arithmetic expectation. A design that cleared the store, or drained at the wrong rate, would release early or late here. Other runs stretch charging well past full and then dip without a tick; a store that did not saturate would wrap and never release, or release at the wrong time. Further runs dwell inside the hysteresis band, withhold ticks and raise both flags at once. These catch a design that leaks the count in the band, counts without a tick or lets the good-supply flag win.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'd0,
    MODE_CHARGE = 2'd1,
    MODE_DRAIN  = 2'd2
  } por_mode_e;
endpackage

// File: rtl/por_mode_dec.sv
module por_mode_dec
  import por_pkg::*;
(
  input  logic      below_i,
  input  logic      above_i,
  output por_mode_e mode_o
);
  // low supply wins over a good-supply flag
  always_comb begin
    if (below_i)      mode_o = MODE_DRAIN;
    else if (above_i) mode_o = MODE_CHARGE;
    else              mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/por_delay_acc.sv
module por_delay_acc
  import por_pkg::*;
#(
  parameter int unsigned TPLH       = 370,
  parameter int unsigned DRAIN_STEP = 4,
  parameter int unsigned CNT_W      = $clog2(TPLH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  por_mode_e        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam int unsigned        STEP_EFF = (DRAIN_STEP > TPLH) ? TPLH : DRAIN_STEP;
  localparam logic [CNT_W-1:0]   FULL_C   = CNT_W'(TPLH);
  localparam logic [CNT_W-1:0]   STEP_C   = CNT_W'(STEP_EFF);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      unique case (mode_i)
        MODE_CHARGE: if (cnt_q < FULL_C) cnt_d = cnt_q + 1'b1;
        MODE_DRAIN:  cnt_d = (cnt_q >= STEP_C) ? cnt_q - STEP_C : '0;
        default:     cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == FULL_C);

  p_sat_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
  p_no_tick_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_hold_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(cnt_q));
  p_drain_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DRAIN && tick_i && cnt_q != '0) |=> cnt_q < $past(cnt_q));
endmodule

// File: rtl/por_out_reg.sv
module por_out_reg
  import por_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  por_mode_e mode_i,
  input  logic      full_i,
  output logic      rst_no
);
  logic rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rel_q <= 1'b0;
    else if (mode_i == MODE_DRAIN)               rel_q <= 1'b0;
    else if (mode_i == MODE_CHARGE && full_i)    rel_q <= 1'b1;
  end

  assign rst_no = rel_q;

  p_release_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(full_i));
  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(rel_q));
endmodule

// File: rtl/por_release_timer.sv
module por_release_timer
  import por_pkg::*;
#(
  parameter int unsigned TPLH       = 370,
  parameter int unsigned DRAIN_STEP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic below_det_i,
  input  logic above_rel_i,
  output logic rst_no
);
  localparam int unsigned CNT_W = $clog2(TPLH + 1);

  por_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             full;

  por_mode_dec u_dec (
    .below_i (below_det_i),
    .above_i (above_rel_i),
    .mode_o  (mode)
  );

  por_delay_acc #(
    .TPLH       (TPLH),
    .DRAIN_STEP (DRAIN_STEP),
    .CNT_W      (CNT_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .mode_i (mode),
    .cnt_o  (cnt),
    .full_o (full)
  );

  por_out_reg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .full_i (full),
    .rst_no (rst_no)
  );

  p_low_on_detect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_det_i |=> !rst_no);
  p_both_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_det_i && above_rel_i) |=> !rst_no);
endmodule

// File: tb/por_release_timer_tb.sv
module por_release_timer_tb;
  localparam int T      = 8;
  localparam int S      = 3;
  localparam int CLK_P  = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic below_det_i = 1'b0;
  logic above_rel_i = 1'b0;
  logic rst_no;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  por_release_timer #(.TPLH(T), .DRAIN_STEP(S)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .below_det_i(below_det_i), .above_rel_i(above_rel_i), .rst_no(rst_no)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic a, input logic t);
    below_det_i = b; above_rel_i = a; tick_i = t;
  endtask

  // good supply with ticks; count edges until release
  task automatic measure(input string req, input int exp);
    int k;
    drive(0, 1, 1);
    for (k = 1; k <= 60; k++) begin
      @(negedge clk_i);
      if (rst_no) break;
    end
    check(req, k, exp);
  endtask

  function automatic int rel_after(input int ticks);
    int rem;
    rem = T - ticks * S;
    if (rem < 0) rem = 0;
    return T - rem + 1;
  endfunction

  initial begin
    drive(0, 0, 0);
    repeat (3) @(negedge clk_i);
    check("R1 reset low", int'(rst_no), 0);
    rst_ni = 1'b1;
    measure("R1 full delay from reset", T + 1);

    // R8: no tick, no progress
    rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1;
    drive(0, 1, 0);
    repeat (10) @(negedge clk_i);
    check("R8 no tick stays low", int'(rst_no), 0);
    measure("R8 charge waits for ticks", T + 1);

    // R5 sweep of dip lengths
    for (int n = 0; n <= 4; n++) begin
      drive(0, 1, 1);
      repeat (T + 3) @(negedge clk_i);
      check("R4 released before dip", int'(rst_no), 1);
      if (n == 0) begin
        drive(1, 0, 0); @(negedge clk_i);
      end else begin
        for (int i = 0; i < n; i++) begin
          drive(1, 0, 1); @(negedge clk_i);
        end
      end
      check("R2 dip drives reset low", int'(rst_no), 0);
      drive(0, 0, 1);
      repeat (4) @(negedge clk_i);
      check("R6 band keeps reset low", int'(rst_no), 0);
      measure("R5 shortened delay", rel_after(n));
    end

    // R6: band after release keeps output high
    drive(0, 0, 1);
    repeat (6) @(negedge clk_i);
    check("R6 band keeps reset high", int'(rst_no), 1);

    // R3: long overcharge then tickless dip
    drive(0, 1, 1);
    repeat (40) @(negedge clk_i);
    drive(1, 0, 0); @(negedge clk_i);
    check("R2 tickless dip low", int'(rst_no), 0);
    measure("R3 store saturated at full", 1);

    // R7: both flags
    drive(1, 1, 1); @(negedge clk_i);
    check("R7 both flags reset low", int'(rst_no), 0);
    @(negedge clk_i);
    measure("R7 both flags drain", rel_after(2));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule